// File: doc/BRIEF.md
# Legacy Platform System Control Registers

This block is a byte-wide register file for the I/O port space of a legacy PC-style board. It sits behind a simple synchronous request port. A request is presented for one cycle with a 16-bit port address, a read/write flag and a write byte. The block accepts it on that clock edge and answers with a one-cycle acknowledge on the next cycle.

Writes to a handful of ports drive board-level control outputs: a soft-reset line, a little-endian mode flag, a disk activity light, a 4-bit system control field and an I/O map type bit. Writes to two further ports produce single-cycle lock-toggle strobes for an external NVRAM. Several ports return fixed board identification bytes. Any port that is not decoded reads as all ones, and writes to it are dropped. A two-byte scratch pair can be read and written freely.

Top module: `sysctl_regs`

## Requirements
- R1: While `rst` is high at a clock edge, all control outputs, both strobes, `ack`, `rd_data` and both scratch bytes become zero.
- R2: A request with `req_valid` high at an edge gives `ack` high in the following cycle only. `rd_data` then carries the read value for a read, and 0x00 for a write.
- R3: A write to port 0x0092 sets `soft_reset` from data bit 0 and `little_endian` from data bit 1, effective from the accepting edge. A read of 0x0092 returns 0x00.
- R4: A write to port 0x0808 sets `disk_light` from data bit 0. A read of 0x0808 returns 0xFF.
- R5: A write to port 0x081C stores data bits 3:0 into `sys_ctrl`. A read of 0x081C returns the stored value with bits 7:4 zero.
- R6: A write to port 0x0850 sets `io_map_sparse` from data bit 0 (0 = contiguous map, 1 = non-contiguous map). A read returns that bit in bit 0, with the other bits zero.
- R7: A write to port 0x0810 raises `lock_strobe_a`, and a write to port 0x0812 raises `lock_strobe_b`. Each strobe is high for exactly the one cycle after the accepting edge. Reads never raise a strobe.
- R8: Reads return fixed identity bytes: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00 and 0x0823 gives 0x03.
- R9: A read of any port not named in R3 to R8 or R11 returns 0xFF. This includes 0x0812, 0x0814 and the other undecoded ports from 0x0800 to 0x0851.
- R10: A write to an identity port or an undecoded port changes no output and no stored value.
- R11: Ports 0x0398 and 0x0399 are two independent read/write scratch bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Port address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | Request answered, one cycle after acceptance |
| rd_data | output | 8 | Read byte, valid with ack |
| soft_reset | output | 1 | Soft-reset request line |
| little_endian | output | 1 | Little-endian mode flag |
| disk_light | output | 1 | Disk activity light state |
| sys_ctrl | output | 4 | System control field |
| io_map_sparse | output | 1 | I/O map type, 1 = non-contiguous |
| lock_strobe_a | output | 1 | NVRAM lock-toggle strobe 1 |
| lock_strobe_b | output | 1 | NVRAM lock-toggle strobe 2 |

## Verification
Every stored bit drives a port directly, so a wrong control register shows up at its output in the cycle after the write that corrupted it. Decode faults can hit a neighbouring field or a dropped write, and these appear at the same moment. A faulty read mux or scratch byte is seen on `rd_data` with the acknowledge of the next read of that port. The random mix therefore rereads every port often and compares all outputs after each access. A strobe that is stuck or stretched shows in the cycle after any access.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int CTRL_W = 4;

    localparam logic [ADDR_W-1:0] PORT_RST_END = 16'h0092;
    localparam logic [ADDR_W-1:0] PORT_LIGHT   = 16'h0808;
    localparam logic [ADDR_W-1:0] PORT_SYSCTL  = 16'h081C;
    localparam logic [ADDR_W-1:0] PORT_MAP     = 16'h0850;
    localparam logic [ADDR_W-1:0] PORT_LOCK_A  = 16'h0810;
    localparam logic [ADDR_W-1:0] PORT_LOCK_B  = 16'h0812;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_RST_END,
        SEL_LIGHT,
        SEL_SYSCTL,
        SEL_MAP,
        SEL_LOCK_A,
        SEL_LOCK_B,
        SEL_IDENT,
        SEL_SCRATCH
    } sel_e;

    typedef struct packed {
        logic              soft_reset;
        logic              little_endian;
        logic              disk_light;
        logic [CTRL_W-1:0] sys_ctrl;
        logic              io_map_sparse;
    } ctrl_t;

    // Fixed identity bytes; 0x0810 doubles as the write strobe port.
    function automatic logic [DATA_W-1:0] ident_value(logic [ADDR_W-1:0] a);
        case (a)
            16'h0800: return 8'hEF;
            16'h0802: return 8'hAD;
            16'h0803: return 8'hE0;
            16'h080C: return 8'h3C;
            16'h0810: return 8'h39;
            16'h0818: return 8'h00;
            16'h0823: return 8'h03;
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic logic is_ident(logic [ADDR_W-1:0] a);
        case (a)
            16'h0800, 16'h0802, 16'h0803, 16'h080C,
            16'h0818, 16'h0823: return 1'b1;
            default:            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SCR_BASE = 16'h0398,
    parameter int                SCR_N    = 2,
    localparam int               IDX_W    = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  scr_idx
);
    logic [ADDR_W-1:0] scr_off;

    always_comb begin
        scr_off = addr - SCR_BASE;
        scr_idx = scr_off[IDX_W-1:0];
        sel     = SEL_NONE;
        if (scr_off < ADDR_W'(SCR_N)) begin
            sel = SEL_SCRATCH;
        end else if (addr == PORT_RST_END) begin
            sel = SEL_RST_END;
        end else if (addr == PORT_LIGHT) begin
            sel = SEL_LIGHT;
        end else if (addr == PORT_SYSCTL) begin
            sel = SEL_SYSCTL;
        end else if (addr == PORT_MAP) begin
            sel = SEL_MAP;
        end else if (addr == PORT_LOCK_A) begin
            sel = SEL_LOCK_A;
        end else if (addr == PORT_LOCK_B) begin
            sel = SEL_LOCK_B;
        end else if (is_ident(addr)) begin
            sel = SEL_IDENT;
        end
    end
endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic              lock_a,
    output logic              lock_b
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            lock_a <= 1'b0;
            lock_b <= 1'b0;
        end else begin
            lock_a <= 1'b0;
            lock_b <= 1'b0;
            if (wr_en) begin
                case (sel)
                    SEL_RST_END: begin
                        ctrl.soft_reset    <= wdata[0];
                        ctrl.little_endian <= wdata[1];
                    end
                    SEL_LIGHT:  ctrl.disk_light    <= wdata[0];
                    SEL_SYSCTL: ctrl.sys_ctrl      <= wdata[CTRL_W-1:0];
                    SEL_MAP:    ctrl.io_map_sparse <= wdata[0];
                    SEL_LOCK_A: lock_a <= 1'b1;
                    SEL_LOCK_B: lock_b <= 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sysctl_scratch.sv
module sysctl_scratch
    import sysctl_pkg::*;
#(
    parameter int  SCR_N = 2,
    localparam int IDX_W = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_byte
);
    logic [DATA_W-1:0] bytes_q [SCR_N];

    for (genvar g = 0; g < SCR_N; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_q[g] <= '0;
            end else if (wr_en && idx == IDX_W'(g)) begin
                bytes_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < SCR_N; i++) begin
            if (idx == IDX_W'(i)) rd_byte = bytes_q[i];
        end
    end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [15:0] SCR_BASE = 16'h0398,
    parameter int          SCR_N    = 2,
    localparam int         IDX_W    = (SCR_N > 1) ? $clog2(SCR_N) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        ack,
    output logic [7:0]  rd_data,
    output logic        soft_reset,
    output logic        little_endian,
    output logic        disk_light,
    output logic [3:0]  sys_ctrl,
    output logic        io_map_sparse,
    output logic        lock_strobe_a,
    output logic        lock_strobe_b
);
    sel_e              sel;
    logic [IDX_W-1:0]  scr_idx;
    logic [DATA_W-1:0] scr_byte;
    logic [DATA_W-1:0] rd_mux;
    ctrl_t             ctrl;
    logic              wr_en;

    assign wr_en = req_valid && req_write;

    sysctl_decode #(.SCR_BASE(SCR_BASE), .SCR_N(SCR_N)) u_decode (
        .addr    (req_addr),
        .sel     (sel),
        .scr_idx (scr_idx)
    );

    sysctl_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (req_wdata),
        .ctrl   (ctrl),
        .lock_a (lock_strobe_a),
        .lock_b (lock_strobe_b)
    );

    sysctl_scratch #(.SCR_N(SCR_N)) u_scratch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en && sel == SEL_SCRATCH),
        .idx     (scr_idx),
        .wdata   (req_wdata),
        .rd_byte (scr_byte)
    );

    always_comb begin
        case (sel)
            SEL_RST_END:           rd_mux = '0;
            SEL_SYSCTL:            rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl.sys_ctrl};
            SEL_MAP:               rd_mux = {{(DATA_W-1){1'b0}}, ctrl.io_map_sparse};
            SEL_LOCK_A, SEL_IDENT: rd_mux = ident_value(req_addr);
            SEL_SCRATCH:           rd_mux = scr_byte;
            default:               rd_mux = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack     <= 1'b0;
            rd_data <= '0;
        end else begin
            ack     <= req_valid;
            rd_data <= (req_valid && !req_write) ? rd_mux : '0;
        end
    end

    assign soft_reset    = ctrl.soft_reset;
    assign little_endian = ctrl.little_endian;
    assign disk_light    = ctrl.disk_light;
    assign sys_ctrl      = ctrl.sys_ctrl;
    assign io_map_sparse = ctrl.io_map_sparse;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
    import sysctl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [15:0] req_addr,
    input logic [7:0]  req_wdata,
    input logic        ack,
    input logic [7:0]  rd_data,
    input logic        soft_reset,
    input logic        little_endian,
    input logic        disk_light,
    input logic [3:0]  sys_ctrl,
    input logic        io_map_sparse,
    input logic        lock_strobe_a,
    input logic        lock_strobe_b
);
    // R2
    ack_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ack);

    // R2
    no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !ack);

    // R7
    strobe_a_cause_chk: assert property (@(posedge clk) disable iff (rst)
        lock_strobe_a |-> $past(req_valid && req_write && req_addr == PORT_LOCK_A));

    // R7
    strobe_b_cause_chk: assert property (@(posedge clk) disable iff (rst)
        lock_strobe_b |-> $past(req_valid && req_write && req_addr == PORT_LOCK_B));

    // R7
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lock_strobe_a, lock_strobe_b}));

    // R3
    soft_reset_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(soft_reset) |-> $past(req_valid && req_write && req_addr == PORT_RST_END));

    // R3
    port92_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == PORT_RST_END) |=> rd_data == 8'h00);

    // R5
    sysctl_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sys_ctrl) |-> $past(req_valid && req_write && req_addr == PORT_SYSCTL));

    // R6
    map_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(io_map_sparse) |-> $past(req_valid && req_write && req_addr == PORT_MAP));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == 16'h0814) |=> rd_data == 8'hFF);
endmodule

bind sysctl_regs sysctl_regs_chk chk_i (.*);

// File: tb/sysctl_regs_tb_top.sv
`timescale 1ns/1ps
module sysctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rd_data;
    logic        soft_reset, little_endian, disk_light, io_map_sparse;
    logic [3:0]  sys_ctrl;
    logic        lock_strobe_a, lock_strobe_b;

    always #2 clk = ~clk;

    sysctl_regs dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench-side expected state
    logic       m_rst, m_le, m_light, m_map;
    logic [3:0] m_ctrl;
    logic [7:0] m_scr [2];

    localparam logic [15:0] POOL [16] = '{16'h0092, 16'h0808, 16'h081C, 16'h0850,
        16'h0810, 16'h0812, 16'h0800, 16'h0802, 16'h0803, 16'h080C, 16'h0818,
        16'h0823, 16'h0398, 16'h0399, 16'h0814, 16'h0851};

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [15:0] a);
        case (a)
            16'h0092: return 8'h00;              // R3
            16'h081C: return {4'h0, m_ctrl};     // R5
            16'h0850: return {7'h0, m_map};      // R6
            16'h0800: return 8'hEF;              // R8
            16'h0802: return 8'hAD;
            16'h0803: return 8'hE0;
            16'h080C: return 8'h3C;
            16'h0810: return 8'h39;
            16'h0818: return 8'h00;
            16'h0823: return 8'h03;
            16'h0398: return m_scr[0];           // R11
            16'h0399: return m_scr[1];
            default:  return 8'hFF;              // R9, R4 read
        endcase
    endfunction

    task automatic model_reset();
        m_rst = 0; m_le = 0; m_light = 0; m_map = 0; m_ctrl = 0;
        m_scr[0] = 0; m_scr[1] = 0;
    endtask

    task automatic check_outputs(string tag, logic sa, logic sb);
        check({tag, " soft_reset R3"},    16'(soft_reset),    16'(m_rst));
        check({tag, " little_endian R3"}, 16'(little_endian), 16'(m_le));
        check({tag, " disk_light R4"},    16'(disk_light),    16'(m_light));
        check({tag, " sys_ctrl R5"},      16'(sys_ctrl),      16'(m_ctrl));
        check({tag, " io_map R6"},        16'(io_map_sparse), 16'(m_map));
        check({tag, " strobe_a R7"},      16'(lock_strobe_a), 16'(sa));
        check({tag, " strobe_b R7"},      16'(lock_strobe_b), 16'(sb));
    endtask

    task automatic access(bit wr, logic [15:0] a, logic [7:0] d, string tag);
        logic [7:0] exp_rd;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        exp_rd = wr ? 8'h00 : exp_read(a);
        if (wr) begin
            case (a)
                16'h0092: begin m_rst = d[0]; m_le = d[1]; end
                16'h0808: m_light = d[0];
                16'h081C: m_ctrl = d[3:0];
                16'h0850: m_map = d[0];
                16'h0398: m_scr[0] = d;
                16'h0399: m_scr[1] = d;
                default: ;   // R10: no stored effect
            endcase
        end
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " ack R2"}, 16'(ack), 16'd1);
        check({tag, " rd_data"}, 16'(rd_data), 16'(exp_rd));
        check_outputs(tag, wr && a == 16'h0810, wr && a == 16'h0812);
    endtask

    task automatic idle_check(string tag);
        @(negedge clk);
        check({tag, " idle ack R2"}, 16'(ack), 16'd0);
        check_outputs({tag, " idle"}, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("reset ack R1", 16'(ack), 16'd0);
        check("reset rd_data R1", 16'(rd_data), 16'd0);
        check_outputs("reset R1", 1'b0, 1'b0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired cycles=%0d exp<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        do_reset();
        access(0, 16'h0398, 8'h00, "R1 scratch0 after reset");
        access(0, 16'h0399, 8'h00, "R1 scratch1 after reset");

        // R3
        access(1, 16'h0092, 8'h03, "R3 set both");
        access(0, 16'h0092, 8'h00, "R3 read 92");
        access(1, 16'h0092, 8'hFE, "R3 clear reset keep le");
        access(1, 16'h0092, 8'h01, "R3 reset only");
        // R4
        access(1, 16'h0808, 8'hFF, "R4 light on");
        access(0, 16'h0808, 8'h00, "R4 read FF");
        access(1, 16'h0808, 8'hFE, "R4 light off");
        // R5
        access(1, 16'h081C, 8'hA5, "R5 low nibble");
        access(0, 16'h081C, 8'h00, "R5 readback");
        // R6
        access(1, 16'h0850, 8'h81, "R6 sparse");
        access(0, 16'h0850, 8'h00, "R6 readback");
        // R7
        access(1, 16'h0810, 8'h00, "R7 strobe a");
        idle_check("R7 a one cycle");
        access(1, 16'h0812, 8'h55, "R7 strobe b");
        idle_check("R7 b one cycle");
        access(0, 16'h0810, 8'h00, "R7 R8 read 810 no strobe");
        access(0, 16'h0812, 8'h00, "R7 R9 read 812 no strobe");
        // R8
        foreach (POOL[i]) access(0, POOL[i], 8'h00, "R8 R9 sweep read");
        // R10
        access(1, 16'h0800, 8'h12, "R10 write ident");
        access(0, 16'h0800, 8'h00, "R10 ident unchanged");
        access(1, 16'h0814, 8'hFF, "R10 write unmapped");
        access(1, 16'h0399, 8'h3C, "R11 scratch1 write");
        access(1, 16'h0398, 8'hC3, "R11 scratch0 write");
        access(0, 16'h0399, 8'h00, "R11 scratch1 independent");
        access(0, 16'h039A, 8'h00, "R9 past scratch");
        idle_check("R2 idle");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            bit          wr;
            if ($urandom_range(3) == 0) a = 16'h0800 + 16'($urandom_range(16'h51));
            else                        a = POOL[$urandom_range(15)];
            wr = $urandom_range(1) == 1;
            access(wr, a, 8'($urandom), "R10 random mix");
            if ($urandom_range(7) == 0) idle_check("R2 random idle");
        end

        do_reset();
        access(0, 16'h0398, 8'h00, "R1 scratch cleared");
        access(0, 16'h081C, 8'h00, "R1 sysctl cleared");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule